// File: doc/BRIEF.md
# Four-Phase Write Link Between Clock Domains

This block carries single-word writes from one clock domain to another over a self-timed request/acknowledge handshake. The two sides share no clock. A master side takes a write command (address and data) from a local ready/valid interface. It drives the address, data and write-enable lines first and raises request only after that. The slave side captures the word into a small register file, raises acknowledge, and waits for request to fall before it drops acknowledge. Each side sees the other's handshake line through a two-flop synchronizer in its own clock domain.

A write is complete when all four handshake edges have happened. This is not tied to a fixed number of cycles of any one clock. The local interface reports busy from the moment a command is accepted until acknowledge has returned low. The register file has a combinational read port in the slave clock domain, so its contents can be inspected.

Top module: `fourphase_wr_link`

## Requirements
- R1: After reset, cmd_ready is 1, link_req, link_ack and link_we are 0, and every register-file word reads 0.
- R2: link_we is high for at least one master clock cycle before link_req rises. Address and data are driven from that same cycle onward.
- R3: The slave raises link_ack only while link_req is high. By the time acknowledge is high, the addressed word holds the written data.
- R4: The master lowers link_req only while link_ack is high, after it has seen acknowledge through its synchronizer.
- R5: The slave lowers link_ack only while link_req is low.
- R6: cmd_ready is 1 only while link_req and link_ack are both low. It is 0 from the cycle after a command is accepted until acknowledge has been seen low.
- R7: The link address and data do not change while link_req stays high.
- R8: A cmd_valid pulse while cmd_ready is 0 is ignored: it starts no handshake and changes no register-file word.
- R9: Every accepted command writes its data to the register-file word at cmd_addr. A later write to the same address replaces the earlier one, and other words keep their contents.
- R10: Each accepted command produces exactly one rising edge of link_req.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| m_clk | input | 1 | Master-side clock |
| m_rst_n | input | 1 | Master-side active-low reset |
| s_clk | input | 1 | Slave-side clock |
| s_rst_n | input | 1 | Slave-side active-low reset |
| cmd_valid | input | 1 | Write command present (master domain) |
| cmd_ready | output | 1 | Master can accept a command |
| cmd_addr | input | AW | Target word index |
| cmd_data | input | DW | Word to write |
| rd_addr | input | AW | Register-file read index (slave domain) |
| rd_data | output | DW | Register-file word at rd_addr |
| link_req | output | 1 | Handshake request, master to slave |
| link_ack | output | 1 | Handshake acknowledge, slave to master |
| link_we | output | 1 | Write-direction line driven by the master |

## Verification
The master and slave run at unrelated periods, so the handshake edges land at shifting phases. A design that raised request in the same cycle as the address, or dropped request before acknowledge, would show up as an out-of-order edge in the monitors. Commands presented while the link is busy are checked against the register file: a master that latched them would overwrite a word or issue an extra request edge. Repeated writes to one address and writes to every address catch a slave that latches stale address or data, or that writes twice per handshake.

// File: rtl/fp_pkg.sv
package fp_pkg;
    typedef enum logic [1:0] {
        M_IDLE  = 2'd0,
        M_SETUP = 2'd1,
        M_REQ   = 2'd2,
        M_REL   = 2'd3
    } m_state_e;
endpackage

// File: rtl/fp_sync.sv
module fp_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] chain_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= {chain_q[STAGES-2:0], din};
    end

    assign dout = chain_q[STAGES-1];
endmodule

// File: rtl/fp_master.sv
module fp_master
    import fp_pkg::*;
#(
    parameter int DW = 16,
    parameter int AW = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cmd_valid,
    output logic          cmd_ready,
    input  logic [AW-1:0] cmd_addr,
    input  logic [DW-1:0] cmd_data,
    input  logic          ack_sync,
    output logic          req,
    output logic          we,
    output logic [AW-1:0] addr,
    output logic [DW-1:0] data
);
    typedef struct packed {
        m_state_e      st;
        logic          req;
        logic          we;
        logic [AW-1:0] addr;
        logic [DW-1:0] data;
    } m_regs_t;

    m_regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        unique case (r_q.st)
            M_IDLE: begin
                if (cmd_valid) begin
                    r_d.addr = cmd_addr;
                    r_d.data = cmd_data;
                    r_d.we   = 1'b1;
                    r_d.st   = M_SETUP;
                end
            end
            M_SETUP: begin
                r_d.req = 1'b1;
                r_d.st  = M_REQ;
            end
            M_REQ: begin
                if (ack_sync) begin
                    r_d.req = 1'b0;
                    r_d.st  = M_REL;
                end
            end
            M_REL: begin
                if (!ack_sync) begin
                    r_d.we = 1'b0;
                    r_d.st = M_IDLE;
                end
            end
            default: r_d.st = M_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.st   <= M_IDLE;
            r_q.req  <= 1'b0;
            r_q.we   <= 1'b0;
            r_q.addr <= '0;
            r_q.data <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign cmd_ready = (r_q.st == M_IDLE);
    assign req       = r_q.req;
    assign we        = r_q.we;
    assign addr      = r_q.addr;
    assign data      = r_q.data;
endmodule

// File: rtl/fp_slave.sv
module fp_slave #(
    parameter int DW    = 16,
    parameter int DEPTH = 8,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_sync,
    input  logic          we,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] data,
    output logic          ack,
    input  logic [AW-1:0] rd_addr,
    output logic [DW-1:0] rd_data
);
    typedef struct packed {
        logic                    ack;
        logic [DEPTH-1:0][DW-1:0] mem;
    } s_regs_t;

    s_regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (!r_q.ack && req_sync) begin
            if (we) r_d.mem[addr] = data;
            r_d.ack = 1'b1;
        end else if (r_q.ack && !req_sync) begin
            r_d.ack = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.ack <= 1'b0;
            r_q.mem <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign ack     = r_q.ack;
    assign rd_data = r_q.mem[rd_addr];
endmodule

// File: rtl/fourphase_wr_link.sv
module fourphase_wr_link #(
    parameter int DW         = 16,
    parameter int DEPTH      = 8,
    parameter int SYNC_STAGES = 2,
    localparam int AW        = $clog2(DEPTH)
) (
    input  logic          m_clk,
    input  logic          m_rst_n,
    input  logic          s_clk,
    input  logic          s_rst_n,
    input  logic          cmd_valid,
    output logic          cmd_ready,
    input  logic [AW-1:0] cmd_addr,
    input  logic [DW-1:0] cmd_data,
    input  logic [AW-1:0] rd_addr,
    output logic [DW-1:0] rd_data,
    output logic          link_req,
    output logic          link_ack,
    output logic          link_we
);
    logic          req_w, ack_w, we_w;
    logic          req_s, ack_s;
    logic [AW-1:0] bus_addr;
    logic [DW-1:0] bus_data;

    fp_master #(.DW(DW), .AW(AW)) u_master (
        .clk       (m_clk),
        .rst_n     (m_rst_n),
        .cmd_valid (cmd_valid),
        .cmd_ready (cmd_ready),
        .cmd_addr  (cmd_addr),
        .cmd_data  (cmd_data),
        .ack_sync  (ack_s),
        .req       (req_w),
        .we        (we_w),
        .addr      (bus_addr),
        .data      (bus_data)
    );

    fp_sync #(.STAGES(SYNC_STAGES)) u_req_sync (
        .clk   (s_clk),
        .rst_n (s_rst_n),
        .din   (req_w),
        .dout  (req_s)
    );

    fp_sync #(.STAGES(SYNC_STAGES)) u_ack_sync (
        .clk   (m_clk),
        .rst_n (m_rst_n),
        .din   (ack_w),
        .dout  (ack_s)
    );

    fp_slave #(.DW(DW), .DEPTH(DEPTH), .AW(AW)) u_slave (
        .clk      (s_clk),
        .rst_n    (s_rst_n),
        .req_sync (req_s),
        .we       (we_w),
        .addr     (bus_addr),
        .data     (bus_data),
        .ack      (ack_w),
        .rd_addr  (rd_addr),
        .rd_data  (rd_data)
    );

    assign link_req = req_w;
    assign link_ack = ack_w;
    assign link_we  = we_w;
endmodule

// File: rtl/fp_link_chk.sv
module fp_link_chk #(
    parameter int DW = 16,
    parameter int AW = 3
) (
    input logic          m_clk,
    input logic          m_rst_n,
    input logic          s_clk,
    input logic          s_rst_n,
    input logic          req,
    input logic          ack,
    input logic          we,
    input logic          cmd_ready,
    input logic [AW-1:0] addr,
    input logic [DW-1:0] data
);
    AST_WE_BEFORE_REQ: assert property (@(posedge m_clk) disable iff (!m_rst_n)
        $rose(req) |-> $past(we)); // R2

    AST_ACK_NEEDS_REQ: assert property (@(posedge s_clk) disable iff (!s_rst_n)
        $rose(ack) |-> req); // R3

    AST_REQ_DROP_AFTER_ACK: assert property (@(posedge m_clk) disable iff (!m_rst_n)
        $fell(req) |-> ack); // R4

    AST_ACK_DROP_AFTER_REQ: assert property (@(posedge s_clk) disable iff (!s_rst_n)
        $fell(ack) |-> !req); // R5

    AST_READY_LINK_IDLE: assert property (@(posedge m_clk) disable iff (!m_rst_n)
        cmd_ready |-> (!req && !ack)); // R6

    AST_BUS_STABLE: assert property (@(posedge m_clk) disable iff (!m_rst_n)
        (req && $past(req)) |-> ($stable(addr) && $stable(data))); // R7
endmodule

bind fourphase_wr_link fp_link_chk #(.DW(DW), .AW(AW)) u_chk (
    .m_clk     (m_clk),
    .m_rst_n   (m_rst_n),
    .s_clk     (s_clk),
    .s_rst_n   (s_rst_n),
    .req       (link_req),
    .ack       (link_ack),
    .we        (link_we),
    .cmd_ready (cmd_ready),
    .addr      (bus_addr),
    .data      (bus_data)
);

// File: tb/sim_fourphase_wr_link.sv
`timescale 1ns/100ps
module sim_fourphase_wr_link;
    localparam int DW = 16;
    localparam int DEPTH = 8;
    localparam int AW = $clog2(DEPTH);

    logic m_clk = 1'b0, s_clk = 1'b0;
    logic m_rst_n = 1'b0, s_rst_n = 1'b0;
    logic cmd_valid = 1'b0;
    logic [AW-1:0] cmd_addr = '0, rd_addr = '0;
    logic [DW-1:0] cmd_data = '0;
    logic cmd_ready, link_req, link_ack, link_we;
    logic [DW-1:0] rd_data;

    int checks = 0, errors = 0;
    int accepted = 0, req_rises = 0;
    bit done = 1'b0;
    logic [DW-1:0] model [DEPTH];

    always #4 m_clk = ~m_clk;
    always #6.5 s_clk = ~s_clk;

    fourphase_wr_link #(.DW(DW), .DEPTH(DEPTH)) u0 (
        .m_clk(m_clk), .m_rst_n(m_rst_n), .s_clk(s_clk), .s_rst_n(s_rst_n),
        .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_addr(cmd_addr),
        .cmd_data(cmd_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .link_req(link_req), .link_ack(link_ack), .link_we(link_we)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Monitors on the master clock (sampled at falling edge)
    logic prev_req = 1'b0, prev_we = 1'b0;
    always @(negedge m_clk) begin
        if (m_rst_n) begin
            if (link_req && !prev_req) begin
                req_rises++;
                check(prev_we && link_we, "R2 we before req", int'(prev_we), 1);
            end
            if (!link_req && prev_req)
                check(link_ack, "R4 req falls with ack high", int'(link_ack), 1);
            if (cmd_ready)
                check(!link_req && !link_ack, "R6 ready with idle link",
                      int'({link_req, link_ack}), 0);
        end
        prev_req = link_req;
        prev_we  = link_we;
    end

    // Monitors on the slave clock
    logic prev_ack = 1'b0;
    always @(negedge s_clk) begin
        if (s_rst_n) begin
            if (link_ack && !prev_ack)
                check(link_req, "R3 ack rises with req high", int'(link_req), 1);
            if (!link_ack && prev_ack)
                check(!link_req, "R5 ack falls with req low", int'(link_req), 0);
        end
        prev_ack = link_ack;
    end

    task automatic wait_idle();
        @(negedge m_clk);
        while (!cmd_ready) @(negedge m_clk);
    endtask

    task automatic write_word(input logic [AW-1:0] a, input logic [DW-1:0] d);
        wait_idle();
        cmd_valid = 1'b1; cmd_addr = a; cmd_data = d;
        @(negedge m_clk);
        cmd_valid = 1'b0;
        model[a] = d;
        accepted++;
        check(!cmd_ready, "R6 busy after accept", int'(cmd_ready), 0);
    endtask

    task automatic compare_all(input string req);
        for (int i = 0; i < DEPTH; i++) begin
            rd_addr = AW'(i);
            #1;
            check(rd_data == model[i], req, int'(rd_data), int'(model[i]));
        end
    endtask

    initial begin
        for (int i = 0; i < DEPTH; i++) model[i] = '0;
        repeat (5) @(posedge s_clk);
        m_rst_n = 1'b1; s_rst_n = 1'b1;
        @(negedge m_clk);
        check(cmd_ready && !link_req && !link_ack && !link_we, "R1 reset outputs",
              int'({cmd_ready, link_req, link_ack, link_we}), 8);
        compare_all("R1 reset contents");

        // R9: one write, then every address
        write_word(3'd2, 16'hBEEF);
        wait_idle();
        compare_all("R9 single write");
        for (int i = 0; i < DEPTH; i++) write_word(AW'(i), DW'(16'h1000 + i * 16'h0111));
        wait_idle();
        compare_all("R9 every address");

        // R9: same address twice, last wins
        write_word(3'd5, 16'h0A0A);
        write_word(3'd5, 16'h5555);
        wait_idle();
        compare_all("R9 overwrite");

        // R8: valid while busy is ignored
        write_word(3'd1, 16'hC0DE);
        @(negedge m_clk);
        while (!cmd_ready) begin
            cmd_valid = 1'b1; cmd_addr = 3'd6; cmd_data = 16'hDEAD;
            @(negedge m_clk);
        end
        cmd_valid = 1'b0;
        wait_idle();
        repeat (10) @(negedge m_clk);
        check(!link_req, "R8 no extra request", int'(link_req), 0);
        compare_all("R8 busy command ignored");

        // Varied data patterns
        write_word(3'd0, 16'hFFFF);
        write_word(3'd7, 16'h0000);
        write_word(3'd3, 16'h8001);
        wait_idle();
        compare_all("R9 pattern writes");

        repeat (10) @(negedge m_clk);
        check(req_rises == accepted, "R10 one request per command", req_rises, accepted);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge m_clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule